// File: doc/BRIEF.md
# Auxiliary memory bank selector

This block sits beside the CPU bus of an 8-bit computer that carries two 64K RAM banks, a main bank and an auxiliary bank. It watches every CPU access. Accesses to soft-switch locations in the I/O page set or clear a set of mode flags. Every access gets a bank-select bit that tells the RAM whether the byte comes from or goes to the auxiliary bank. The flags cover bank steering (separate read and write banks, plus an 80-column store override) and the display modes (text, mixed, page 2, hi-res, double hi-res, I/O disable).

Reads in the low half of the I/O page return a byte from the block. This byte is a flag status, the idle cassette input, a push-button state, or, for locations with nothing behind them, the byte the video fetch is reading from main RAM. The block builds that fetch address from a base supplied by the video counters, the page-2 state and the low bits of the line count. The RAM reads the fetch address and returns the byte to the block.

Top module: `auxbank_sel`

## Requirements
- R1: Every switch spans two adjacent addresses. On a write to one of them, the flag takes bit 0 of the address (1 sets it, 0 clears it), except in R7. The new value is visible from the next clock cycle on the flag outputs and in steering. The switch pairs are: 80-column store $C000/$C001, read bank $C002/$C003, write bank $C004/$C005, text $C050/$C051, mixed $C052/$C053, page 2 $C054/$C055, hi-res $C056/$C057, double hi-res $C05E/$C05F, I/O disable $C07E/$C07F.
- R2: A read of a status address returns its flag in bit 7 and zero in bits 6..0. The status addresses are: $C013 read bank, $C014 write bank, $C018 80-column store, $C01A text, $C01B mixed, $C01C page 2, $C01D hi-res, $C07E I/O disable, $C07F double hi-res.
- R3: For general memory $0200-$BFFF outside the display regions, aux_sel equals the read-bank flag on reads and the write-bank flag on writes.
- R4: With 80-column store set, aux_sel for the text region $0400-$07FF and the hi-res region $2000-$3FFF equals the page-2 flag, on reads and on writes alike.
- R5: With 80-column store clear, the text and hi-res regions follow the read-bank flag on reads and the write-bank flag on writes.
- R6: The page-2 and hi-res switches act on reads as well as writes. A read of any other switch address leaves every flag unchanged.
- R7: The double hi-res and I/O-disable switches are inverted. The even address of the pair sets the flag and the odd address clears it.
- R8: A read of $C060 returns $5A. A read of $C061 returns btn[0] in bit 7, and a read of $C062 returns btn[1] in bit 7, with the other bits zero.
- R9: Any other read in $C000-$C07F returns float_byte. float_addr is vid_base OR $4000 (when page 2 is set and 80-column store is clear) OR vid_line shifted left by 10.
- R10: Reset clears every flag, so all accesses after reset steer to main RAM.
- R11: Addresses below $0200 and at or above $C000 always steer to main RAM. io_hit is high exactly when acc_en is high and the address lies in $C000-$C07F.
- R12: While acc_en is low, no flag changes, whatever the address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | A CPU access takes place this cycle |
| acc_we | input | 1 | 1 = write access, 0 = read |
| acc_addr | input | 16 | CPU address |
| btn | input | 2 | Push-button levels |
| vid_base | input | 16 | Video fetch base address from the display counters |
| vid_line | input | 3 | Low bits of the vertical line count |
| float_byte | input | 8 | Main-RAM byte at float_addr |
| aux_sel | output | 1 | 1 = this access uses auxiliary RAM |
| io_hit | output | 1 | Access falls in the block's I/O window |
| io_rdata | output | 8 | Read data for the I/O window |
| float_addr | output | 16 | Main-RAM address of the current video fetch |
| mode_text | output | 1 | Text mode flag |
| mode_mixed | output | 1 | Mixed mode flag |
| mode_page2 | output | 1 | Page 2 flag |
| mode_hires | output | 1 | Hi-res flag |
| mode_dhires | output | 1 | Double hi-res flag |

## Verification
The assertions assume that acc_addr and acc_we are stable for the whole cycle in which acc_en is high. They also assume that vid_base leaves bit 14 and bits 12..10 clear, because those bits of the fetch address belong to the page and line terms. The stimulus changes inputs only on the falling edge and draws vid_base through a mask that clears those bits. Random addresses are picked from the switch, status and region-boundary locations, mixed with arbitrary memory addresses, so that every flag is toggled many times in both directions.

// File: rtl/auxbank_pkg.sv
package auxbank_pkg;
  typedef struct packed {
    logic store80;
    logic rd_aux;
    logic wr_aux;
    logic text;
    logic mixed;
    logic page2;
    logic hires;
    logic dhires;
    logic iodis;
  } sw_flags_t;
endpackage

// File: rtl/auxbank_flags.sv
module auxbank_flags
  import auxbank_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [AW-9:0] IO_PAGE = 'hC0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  output sw_flags_t     flags
);
  sw_flags_t nxt;
  logic      in_io;
  logic      b0;

  assign in_io = (acc_addr[AW-1:8] == IO_PAGE);
  assign b0    = acc_addr[0];

  always_comb begin
    nxt = flags;
    if (acc_en && in_io) begin
      case (acc_addr[7:1])
        7'h00: if (acc_we) nxt.store80 = b0;
        7'h01: if (acc_we) nxt.rd_aux  = b0;
        7'h02: if (acc_we) nxt.wr_aux  = b0;
        7'h28: if (acc_we) nxt.text    = b0;
        7'h29: if (acc_we) nxt.mixed   = b0;
        7'h2A: nxt.page2 = b0;
        7'h2B: nxt.hires = b0;
        7'h2F: if (acc_we) nxt.dhires  = ~b0;
        7'h3F: if (acc_we) nxt.iodis   = ~b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= nxt;
  end
endmodule

// File: rtl/auxbank_steer.sv
module auxbank_steer
  import auxbank_pkg::*;
#(
  parameter int            AW     = 16,
  parameter logic [AW-1:0] GEN_LO = 'h0200,
  parameter logic [AW-1:0] GEN_HI = 'hBFFF,
  parameter logic [AW-1:0] TXT_LO = 'h0400,
  parameter logic [AW-1:0] TXT_HI = 'h07FF,
  parameter logic [AW-1:0] HGR_LO = 'h2000,
  parameter logic [AW-1:0] HGR_HI = 'h3FFF
) (
  input  sw_flags_t     flags,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_we,
  output logic          aux_sel
);
  logic in_gen, in_disp, dir_bank;

  assign in_gen   = (acc_addr >= GEN_LO) && (acc_addr <= GEN_HI);
  assign in_disp  = ((acc_addr >= TXT_LO) && (acc_addr <= TXT_HI)) ||
                    ((acc_addr >= HGR_LO) && (acc_addr <= HGR_HI));
  assign dir_bank = acc_we ? flags.wr_aux : flags.rd_aux;

  always_comb begin
    if (!in_gen)                       aux_sel = 1'b0;
    else if (in_disp && flags.store80) aux_sel = flags.page2;
    else                               aux_sel = dir_bank;
  end
endmodule

// File: rtl/auxbank_rdmux.sv
module auxbank_rdmux
  import auxbank_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            DW      = 8,
  parameter int            LINE_W  = 3,
  parameter int            LINE_SH = 10,
  parameter logic [AW-1:0] PG_BIT  = 'h4000,
  parameter logic [DW-1:0] CASS_ID = 'h5A
) (
  input  sw_flags_t         flags,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        btn,
  input  logic [AW-1:0]     vid_base,
  input  logic [LINE_W-1:0] vid_line,
  input  logic [DW-1:0]     float_byte,
  output logic [DW-1:0]     rdata,
  output logic [AW-1:0]     float_addr
);
  localparam int PAD = DW - 1;
  logic [AW-1:0] line_term;

  assign line_term  = AW'(vid_line) << LINE_SH;
  assign float_addr = vid_base | line_term |
                      ((flags.page2 && !flags.store80) ? PG_BIT : '0);

  always_comb begin
    case (acc_addr[7:0])
      8'h13:   rdata = {flags.rd_aux,  PAD'(0)};
      8'h14:   rdata = {flags.wr_aux,  PAD'(0)};
      8'h18:   rdata = {flags.store80, PAD'(0)};
      8'h1A:   rdata = {flags.text,    PAD'(0)};
      8'h1B:   rdata = {flags.mixed,   PAD'(0)};
      8'h1C:   rdata = {flags.page2,   PAD'(0)};
      8'h1D:   rdata = {flags.hires,   PAD'(0)};
      8'h7E:   rdata = {flags.iodis,   PAD'(0)};
      8'h7F:   rdata = {flags.dhires,  PAD'(0)};
      8'h60:   rdata = CASS_ID;
      8'h61:   rdata = {btn[0],        PAD'(0)};
      8'h62:   rdata = {btn[1],        PAD'(0)};
      default: rdata = float_byte;
    endcase
  end
endmodule

// File: rtl/auxbank_sel.sv
module auxbank_sel
  import auxbank_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        btn,
  input  logic [AW-1:0]     vid_base,
  input  logic [LINE_W-1:0] vid_line,
  input  logic [DW-1:0]     float_byte,
  output logic              aux_sel,
  output logic              io_hit,
  output logic [DW-1:0]     io_rdata,
  output logic [AW-1:0]     float_addr,
  output logic              mode_text,
  output logic              mode_mixed,
  output logic              mode_page2,
  output logic              mode_hires,
  output logic              mode_dhires
);
  localparam logic [AW-9:0] IO_PAGE = (AW-8)'('hC0);
  sw_flags_t sw;

  auxbank_flags #(.AW(AW), .IO_PAGE(IO_PAGE)) u_flags (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .flags(sw)
  );

  auxbank_steer #(.AW(AW)) u_steer (
    .flags(sw), .acc_addr(acc_addr), .acc_we(acc_we), .aux_sel(aux_sel)
  );

  auxbank_rdmux #(.AW(AW), .DW(DW), .LINE_W(LINE_W)) u_rdmux (
    .flags(sw), .acc_addr(acc_addr), .btn(btn), .vid_base(vid_base),
    .vid_line(vid_line), .float_byte(float_byte), .rdata(io_rdata),
    .float_addr(float_addr)
  );

  assign io_hit      = acc_en && (acc_addr[AW-1:8] == IO_PAGE) && !acc_addr[7];
  assign mode_text   = sw.text;
  assign mode_mixed  = sw.mixed;
  assign mode_page2  = sw.page2;
  assign mode_hires  = sw.hires;
  assign mode_dhires = sw.dhires;
endmodule

// File: rtl/auxbank_chk.sv
module auxbank_chk
  import auxbank_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        acc_en,
  input logic        acc_we,
  input logic [15:0] acc_addr,
  input logic        aux_sel,
  input logic [7:0]  io_rdata,
  input sw_flags_t   flags
);
  logic rd_io;
  assign rd_io = acc_en && !acc_we;

  AST_RDBANK_SET: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_addr == 16'hC003) |=> flags.rd_aux); // R1

  AST_DHIRES_INV: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_addr == 16'hC05E) |=> flags.dhires); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(flags)); // R12

  AST_S80_TEXT: assert property (@(posedge clk) disable iff (rst)
    (flags.store80 && acc_addr >= 16'h0400 && acc_addr <= 16'h07FF)
      |-> (aux_sel == flags.page2)); // R4

  AST_IO_MAIN: assert property (@(posedge clk) disable iff (rst)
    (acc_addr >= 16'hC000) |-> !aux_sel); // R11

  AST_STAT_FORM: assert property (@(posedge clk) disable iff (rst)
    (rd_io && acc_addr == 16'hC013) |-> (io_rdata[6:0] == 7'd0)); // R2

  AST_CASS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rd_io && acc_addr == 16'hC060) |-> (io_rdata == 8'h5A)); // R8
endmodule

bind auxbank_sel auxbank_chk u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .aux_sel(aux_sel), .io_rdata(io_rdata), .flags(sw)
);

// File: tb/sim_auxbank_sel.sv
module sim_auxbank_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_we = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  btn = '0;
  logic [15:0] vid_base = '0;
  logic [2:0]  vid_line = '0;
  logic [7:0]  float_byte = '0;
  logic        aux_sel, io_hit;
  logic [7:0]  io_rdata;
  logic [15:0] float_addr;
  logic        mode_text, mode_mixed, mode_page2, mode_hires, mode_dhires;

  int n_chk = 0;
  int n_fail = 0;
  bit m_s80, m_rr, m_rw, m_tx, m_mx, m_p2, m_hr, m_dh, m_io;

  always #2 clk = ~clk;

  auxbank_sel u0 (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .btn(btn), .vid_base(vid_base),
    .vid_line(vid_line), .float_byte(float_byte), .aux_sel(aux_sel),
    .io_hit(io_hit), .io_rdata(io_rdata), .float_addr(float_addr),
    .mode_text(mode_text), .mode_mixed(mode_mixed), .mode_page2(mode_page2),
    .mode_hires(mode_hires), .mode_dhires(mode_dhires)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, acc_addr, act, exp);
    end
  endtask

  function automatic logic exp_aux(input logic [15:0] a, input logic w);
    logic dir;
    dir = w ? m_rw : m_rr;
    if (a < 16'h0200 || a >= 16'hC000) return 1'b0;
    if ((a >= 16'h0400 && a <= 16'h07FF) || (a >= 16'h2000 && a <= 16'h3FFF))
      return m_s80 ? m_p2 : dir;
    return dir;
  endfunction

  function automatic string aux_tag(input logic [15:0] a);
    if (a < 16'h0200 || a >= 16'hC000) return "R11";
    if ((a >= 16'h0400 && a <= 16'h07FF) || (a >= 16'h2000 && a <= 16'h3FFF))
      return m_s80 ? "R4" : "R5";
    return "R3";
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a)
      16'hC013: return {m_rr, 7'd0};
      16'hC014: return {m_rw, 7'd0};
      16'hC018: return {m_s80, 7'd0};
      16'hC01A: return {m_tx, 7'd0};
      16'hC01B: return {m_mx, 7'd0};
      16'hC01C: return {m_p2, 7'd0};
      16'hC01D: return {m_hr, 7'd0};
      16'hC07E: return {m_io, 7'd0};
      16'hC07F: return {m_dh, 7'd0};
      16'hC060: return 8'h5A;
      16'hC061: return {btn[0], 7'd0};
      16'hC062: return {btn[1], 7'd0};
      default:  return float_byte;
    endcase
  endfunction

  function automatic string rd_tag(input logic [15:0] a);
    if (a >= 16'hC060 && a <= 16'hC062) return "R8";
    case (a)
      16'hC013, 16'hC014, 16'hC018, 16'hC01A, 16'hC01B, 16'hC01C,
      16'hC01D, 16'hC07E, 16'hC07F: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic model_upd(input logic [15:0] a, input logic w);
    if (a[15:8] != 8'hC0) return;
    case (a[7:1])
      7'h00: if (w) m_s80 = a[0];
      7'h01: if (w) m_rr = a[0];
      7'h02: if (w) m_rw = a[0];
      7'h28: if (w) m_tx = a[0];
      7'h29: if (w) m_mx = a[0];
      7'h2A: m_p2 = a[0];   // R6 any direction
      7'h2B: m_hr = a[0];
      7'h2F: if (w) m_dh = ~a[0];  // R7
      7'h3F: if (w) m_io = ~a[0];
      default: ;
    endcase
  endtask

  task automatic step(input logic [15:0] a, input logic w, input logic en);
    logic [15:0] fexp;
    logic [4:0]  mexp;
    logic        hexp;
    @(negedge clk);
    acc_addr   = a;
    acc_we     = w;
    acc_en     = en;
    btn        = 2'($urandom);
    vid_base   = 16'($urandom) & 16'hA3FF;
    vid_line   = 3'($urandom);
    float_byte = 8'($urandom);
    #1;
    chk(aux_sel == exp_aux(a, w), aux_tag(a), 16'(aux_sel), 16'(exp_aux(a, w)));
    hexp = en && (a >= 16'hC000) && (a <= 16'hC07F);
    chk(io_hit == hexp, "R11", 16'(io_hit), 16'(hexp));
    if (hexp && !w)
      chk(io_rdata == exp_rd(a), rd_tag(a), 16'(io_rdata), 16'(exp_rd(a)));
    fexp = vid_base | ((m_p2 && !m_s80) ? 16'h4000 : 16'h0000) |
           (16'(vid_line) << 10);
    chk(float_addr == fexp, "R9", float_addr, fexp);
    mexp = {m_tx, m_mx, m_p2, m_hr, m_dh};
    chk({mode_text, mode_mixed, mode_page2, mode_hires, mode_dhires} == mexp,
        "R1", 16'({mode_text, mode_mixed, mode_page2, mode_hires, mode_dhires}),
        16'(mexp));
    @(posedge clk);
    if (en) model_upd(a, w);  // R12: idle cycles leave the model untouched
  endtask

  localparam int NPICK = 24;
  function automatic logic [15:0] pick(input int k);
    case (k)
      0: return 16'hC000;  1: return 16'hC001;  2: return 16'hC002;
      3: return 16'hC003;  4: return 16'hC004;  5: return 16'hC005;
      6: return 16'hC050;  7: return 16'hC051;  8: return 16'hC052;
      9: return 16'hC053; 10: return 16'hC054; 11: return 16'hC055;
     12: return 16'hC056; 13: return 16'hC057; 14: return 16'hC05E;
     15: return 16'hC05F; 16: return 16'hC07E; 17: return 16'hC07F;
     18: return 16'h0400; 19: return 16'h07FF; 20: return 16'h2000;
     21: return 16'h3FFF; 22: return 16'h01FF;
      default: return 16'hC010 + 16'($urandom_range(0, 15));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R10: everything off after reset
    step(16'h0300, 1'b0, 1'b1);
    step(16'h0450, 1'b1, 1'b1);
    // R8 cassette and buttons
    step(16'hC060, 1'b0, 1'b1);
    step(16'hC061, 1'b0, 1'b1);
    step(16'hC062, 1'b0, 1'b1);
    // R7 inverted sense
    step(16'hC05E, 1'b1, 1'b1);
    step(16'hC07F, 1'b0, 1'b1);
    step(16'hC07E, 1'b1, 1'b1);
    step(16'hC07E, 1'b0, 1'b1);
    // R6: read of a write-only switch does nothing, page 2 read toggles
    step(16'hC051, 1'b0, 1'b1);
    step(16'hC055, 1'b0, 1'b1);
    step(16'hC01C, 1'b0, 1'b1);
    // R4: 80-column store makes page 2 steer display regions
    step(16'hC001, 1'b1, 1'b1);
    step(16'h0400, 1'b0, 1'b1);
    step(16'h3FFF, 1'b1, 1'b1);
    step(16'h0800, 1'b0, 1'b1);
    step(16'hC077, 1'b0, 1'b1);
    // R12: idle access to a switch changes nothing
    step(16'hC054, 1'b1, 1'b0);
    step(16'hC01C, 1'b0, 1'b1);
    // R3/R5: split read and write banks
    step(16'hC000, 1'b1, 1'b1);
    step(16'hC003, 1'b1, 1'b1);
    step(16'h0200, 1'b0, 1'b1);
    step(16'hBFFF, 1'b1, 1'b1);
    step(16'h2000, 1'b0, 1'b1);
    step(16'hC014, 1'b0, 1'b1);
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      if ($urandom_range(0, 3) == 0) a = 16'($urandom);
      else a = pick($urandom_range(0, NPICK - 1));
      step(a, 1'($urandom), ($urandom_range(0, 4) != 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule